// File: doc/BRIEF.md
# Dual-Channel Result Combiner

This block sits after a serial capture stage that delivers decoded, signed conversion results from a two-input converter. The converter alternates its input channel on every conversion and marks each result with a channel tag. The combiner watches that tag and pairs a channel-0 result with the channel-1 result that follows it. It then forms one combined value and presents it with a single-cycle valid strobe.

A two-bit method select picks the arithmetic. The difference method subtracts the channel-1 result from the channel-0 result, which gives a pseudo-differential bridge reading. The sum method adds the two results, so that a lead drop seen with opposite signs on the two channels cancels, as in a remote resistive temperature sensor. The drift method uses three samples in the order channel 0, channel 1, channel 0. It averages the two outer readings and subtracts the middle one, which removes slow drift that a single pair would carry into the result.

If two consecutive samples carry the same tag, the alternation has been broken. The block flags a sequence error and starts pairing again from the newer sample. The output is two bits wider than the input, so no method can overflow.

Top module: `dual_chan_combiner`

## Requirements
- R1: After synchronous reset, out_valid, seq_err and out_data are all zero.
- R2: With mode 2'b00, a tag-0 sample `a` followed by a tag-1 sample `b` gives out_data = a - b, with out_valid high for one cycle, in the cycle after `b` is accepted.
- R3: With mode 2'b01, the same pairing gives out_data = a + b, with the same timing as R2.
- R4: With mode 2'b10, the samples tag-0 `a`, tag-1 `b`, tag-0 `c` give out_data = floor((a + c) / 2) - b, in the cycle after `c` is accepted. The halving is an arithmetic right shift, so it rounds toward minus infinity.
- R5: In mode 2'b10, the closing tag-0 sample of one window is also the opening sample of the next. The stream 0,1,0,1,0 therefore yields two results, after the third and the fifth sample.
- R6: A sample whose tag equals the tag of the previous accepted sample raises seq_err for one cycle, in the cycle after it is accepted, and produces no result. A tag-0 sample that triggers the error becomes the new first sample of a pair. A tag-1 sample that triggers the error is discarded.
- R7: A tag-1 sample that arrives with no pending tag-0 sample produces no result.
- R8: out_data is IN_W+2 bits wide. Full-scale positive and negative inputs in every mode give the exact arithmetic result, with no wrap.
- R9: Cycles with in_valid low leave the outputs unchanged apart from clearing the strobes, and do not disturb pairing. in_chan and in_data are ignored during those cycles.
- R10: Mode 2'b11 behaves exactly as mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_chan | input | 1 | Channel tag of the sample (0 or 1) |
| in_data | input | IN_W | Signed conversion result |
| mode | input | 2 | Method: 00 difference, 01 sum, 10 drift, 11 difference |
| out_valid | output | 1 | One-cycle strobe marking a new combined result |
| out_data | output | IN_W+2 | Signed combined result, held until the next result |
| seq_err | output | 1 | One-cycle strobe: tag repeated, pairing restarted |

## Verification
Clean alternating streams are run in each method with values of both signs. These show whether the subtraction order, the addition and the three-sample average are right, and whether odd negative sums in the drift method round down. A long drift run checks that windows overlap. Full-scale values of opposite and equal signs show any loss of the extra output bits. Repeated tags of both kinds, idle gaps filled with junk, mode 11 and a change of method in the middle of a window show whether the sequencer restarts, discards and resumes in the right state.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    // Combination method selected by the mode input.
    typedef enum logic [1:0] {
        CMB_DIFF  = 2'b00,
        CMB_SUM   = 2'b01,
        CMB_DRIFT = 2'b10,
        CMB_RSVD  = 2'b11
    } cmb_mode_e;

    // Pairing progress of the sequencer.
    typedef enum logic [1:0] {
        PS_EMPTY    = 2'b00,
        PS_HAVE_REF = 2'b01,
        PS_HAVE_AUX = 2'b10
    } pair_state_e;

    // Actions the sequencer requests for the current sample.
    typedef struct packed {
        logic ld_ref;
        logic ld_aux;
        logic fire;
        logic err;
    } seq_act_t;

    function automatic logic mode_is_drift(input cmb_mode_e m);
        return m == CMB_DRIFT;
    endfunction

    function automatic logic mode_is_sum(input cmb_mode_e m);
        return m == CMB_SUM;
    endfunction

endpackage

// File: rtl/dcc_pair_seq.sv
module dcc_pair_seq
    import dcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  logic      in_chan,
    input  cmb_mode_e mode,
    output seq_act_t  act
);

    pair_state_e st_q;
    pair_state_e st_d;
    logic        tag_seen_q;
    logic        tag_last_q;
    logic        dup_tag;
    logic        drift;

    assign drift   = mode_is_drift(mode);
    assign dup_tag = tag_seen_q && (in_chan == tag_last_q);

    always_comb begin
        act  = '0;
        st_d = st_q;
        if (in_valid) begin
            act.err = dup_tag;
            if (!in_chan) begin
                // A tag-0 sample always opens a new pair or window.
                act.ld_ref = 1'b1;
                st_d       = PS_HAVE_REF;
                if (st_q == PS_HAVE_AUX && drift) begin
                    act.fire = 1'b1;
                end
            end else begin
                if (st_q == PS_HAVE_REF) begin
                    if (drift) begin
                        act.ld_aux = 1'b1;
                        st_d       = PS_HAVE_AUX;
                    end else begin
                        act.fire = 1'b1;
                        st_d     = PS_EMPTY;
                    end
                end else begin
                    st_d = PS_EMPTY;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= PS_EMPTY;
            tag_seen_q <= 1'b0;
            tag_last_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (in_valid) begin
                tag_seen_q <= 1'b1;
                tag_last_q <= in_chan;
            end
        end
    end

endmodule

// File: rtl/dcc_sample_hold.sv
module dcc_sample_hold #(
    parameter int IN_W = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ld_ref,
    input  logic                   ld_aux,
    input  logic signed [IN_W-1:0] smp,
    output logic signed [IN_W-1:0] ref_q,
    output logic signed [IN_W-1:0] aux_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= '0;
            aux_q <= '0;
        end else begin
            if (ld_ref) ref_q <= smp;
            if (ld_aux) aux_q <= smp;
        end
    end

endmodule

// File: rtl/dcc_combine.sv
module dcc_combine
    import dcc_pkg::*;
#(
    parameter int IN_W = 24
) (
    input  cmb_mode_e              mode,
    input  logic signed [IN_W-1:0] ref_q,
    input  logic signed [IN_W-1:0] aux_q,
    input  logic signed [IN_W-1:0] smp,
    output logic signed [IN_W+1:0] result
);

    localparam int OUT_W = IN_W + 2;

    logic signed [OUT_W-1:0] r_x;
    logic signed [OUT_W-1:0] a_x;
    logic signed [OUT_W-1:0] s_x;
    logic signed [OUT_W-1:0] pair_sum;
    logic signed [OUT_W-1:0] pair_diff;
    logic signed [OUT_W-1:0] outer_sum;
    logic signed [OUT_W-1:0] outer_avg;
    logic signed [OUT_W-1:0] drift_res;

    assign r_x = OUT_W'(ref_q);
    assign a_x = OUT_W'(aux_q);
    assign s_x = OUT_W'(smp);

    assign pair_sum  = r_x + s_x;
    assign pair_diff = r_x - s_x;
    assign outer_sum = r_x + s_x;
    assign outer_avg = outer_sum >>> 1;
    assign drift_res = outer_avg - a_x;

    always_comb begin
        if (mode_is_drift(mode)) begin
            result = drift_res;
        end else if (mode_is_sum(mode)) begin
            result = pair_sum;
        end else begin
            result = pair_diff;
        end
    end

endmodule

// File: rtl/dual_chan_combiner.sv
module dual_chan_combiner
    import dcc_pkg::*;
#(
    parameter int IN_W = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic                   in_chan,
    input  logic signed [IN_W-1:0] in_data,
    input  logic [1:0]             mode,
    output logic                   out_valid,
    output logic signed [IN_W+1:0] out_data,
    output logic                   seq_err
);

    localparam int OUT_W = IN_W + 2;

    cmb_mode_e               mode_e;
    seq_act_t                act;
    logic signed [IN_W-1:0]  ref_q;
    logic signed [IN_W-1:0]  aux_q;
    logic signed [OUT_W-1:0] comb_res;

    assign mode_e = cmb_mode_e'(mode);

    dcc_pair_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_chan  (in_chan),
        .mode     (mode_e),
        .act      (act)
    );

    dcc_sample_hold #(.IN_W(IN_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .ld_ref (act.ld_ref),
        .ld_aux (act.ld_aux),
        .smp    (in_data),
        .ref_q  (ref_q),
        .aux_q  (aux_q)
    );

    dcc_combine #(.IN_W(IN_W)) u_comb (
        .mode   (mode_e),
        .ref_q  (ref_q),
        .aux_q  (aux_q),
        .smp    (in_data),
        .result (comb_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            seq_err   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= act.fire;
            seq_err   <= act.err;
            if (act.fire) out_data <= comb_res;
        end
    end

endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
    parameter int IN_W = 24
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic                   in_chan,
    input logic [1:0]             mode,
    input logic                   out_valid,
    input logic signed [IN_W+1:0] out_data,
    input logic                   seq_err
);

    logic seen_q;
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            last_q <= 1'b0;
        end else if (in_valid) begin
            seen_q <= 1'b1;
            last_q <= in_chan;
        end
    end

    // R9: a result strobe only follows an accepted sample
    a_r9_valid_needs_input: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R9: idle cycles raise neither strobe
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !seq_err));

    // R6: a repeated tag is flagged in the next cycle
    a_r6_repeat_flagged: assert property (@(posedge clk) disable iff (rst)
        (in_valid && seen_q && in_chan == last_q) |=> seq_err);

    // R6: an erroneous sample never yields a result
    a_r6_err_no_result: assert property (@(posedge clk) disable iff (rst)
        !(seq_err && out_valid));

    // R2: a tag-1 sample after a tag-0 sample completes a pair outside drift mode
    a_r2_pair_fires: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_chan && seen_q && !last_q && mode != 2'b10) |=> out_valid);

    // R8: results fit in one bit less than the output, so the top two bits agree
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[IN_W+1] == out_data[IN_W]));

endmodule

bind dual_chan_combiner dcc_checker #(.IN_W(IN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_chan   (in_chan),
    .mode      (mode),
    .out_valid (out_valid),
    .out_data  (out_data),
    .seq_err   (seq_err)
);

// File: tb/dual_chan_combiner_bench.sv
module dual_chan_combiner_bench;

    localparam int  IN_W   = 24;
    localparam int  OUT_W  = IN_W + 2;
    localparam time CLK_P  = 10;
    localparam longint VMAX = (64'sd1 <<< (IN_W - 1)) - 1;
    localparam longint VMIN = -(64'sd1 <<< (IN_W - 1));

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    in_valid = 1'b0;
    logic                    in_chan = 1'b0;
    logic signed [IN_W-1:0]  in_data = '0;
    logic [1:0]              mode = 2'b00;
    logic                    out_valid;
    logic signed [OUT_W-1:0] out_data;
    logic                    seq_err;

    always #(CLK_P / 2) clk = ~clk;

    dual_chan_combiner #(.IN_W(IN_W)) u_dual_chan_combiner (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_chan   (in_chan),
        .in_data   (in_data),
        .mode      (mode),
        .out_valid (out_valid),
        .out_data  (out_data),
        .seq_err   (seq_err)
    );

    int checks = 0;
    int errors = 0;

    // reference model state
    bit     m_seen = 0;
    bit     m_last = 0;
    bit     h_ch[$];
    longint h_d[$];
    bit     exp_valid = 0;
    bit     exp_err = 0;
    longint exp_data = 0;
    string  exp_tag = "R1";

    function automatic longint floor_half(input longint s);
        if (s >= 0) return s / 2;
        return -((-s + 1) / 2);
    endfunction

    task automatic model(input bit v, input bit ch, input longint d, input logic [1:0] m);
        exp_valid = 0;
        exp_err   = 0;
        if (!v) return;
        if (m_seen && ch == m_last) begin
            exp_err = 1;
            h_ch.delete();
            h_d.delete();
        end
        m_seen = 1;
        m_last = ch;
        if (ch && h_ch.size() == 0) return;
        h_ch.push_back(ch);
        h_d.push_back(d);
        if (m != 2'b10 && ch && h_ch.size() >= 2) begin
            exp_valid = 1;
            exp_data  = (m == 2'b01) ? h_d[h_d.size()-2] + d : h_d[h_d.size()-2] - d;
            h_ch.delete();
            h_d.delete();
        end else if (m == 2'b10 && !ch && h_ch.size() >= 3 && h_ch[h_ch.size()-2]) begin
            exp_valid = 1;
            exp_data  = floor_half(h_d[h_d.size()-3] + d) - h_d[h_d.size()-2];
            h_ch = '{ch};
            h_d  = '{d};
        end
        while (h_ch.size() > 3) begin
            void'(h_ch.pop_front());
            void'(h_d.pop_front());
        end
    endtask

    task automatic compare();
        logic signed [OUT_W-1:0] e_d;
        e_d = exp_data[OUT_W-1:0];
        checks++;
        if (out_valid !== exp_valid || seq_err !== exp_err || out_data !== e_d) begin
            errors++;
            $display("FAIL %s: valid=%0b err=%0b data=%0d expected valid=%0b err=%0b data=%0d",
                     exp_tag, out_valid, seq_err, out_data, exp_valid, exp_err, e_d);
        end
    endtask

    task automatic step(input bit v, input bit ch, input longint d,
                        input logic [1:0] m, input string tag);
        @(negedge clk);
        compare();
        in_valid = v;
        in_chan  = ch;
        in_data  = d[IN_W-1:0];
        mode     = m;
        model(v, ch, d, m);
        exp_tag = tag;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state is compared by the first step
        step(0, 0, 0, 2'b00, "R9");
        // R2 difference, both signs
        step(1, 0, 100, 2'b00, "R2");
        step(1, 1, 30, 2'b00, "R2");
        step(1, 0, -5, 2'b00, "R2");
        step(1, 1, 20, 2'b00, "R2");
        // R9 idle gap with junk on data and tag
        step(1, 0, 77, 2'b00, "R9");
        step(0, 1, 12345, 2'b00, "R9");
        step(0, 0, -999, 2'b01, "R9");
        step(1, 1, 7, 2'b00, "R9");
        // R3 sum
        step(1, 0, 1000, 2'b01, "R3");
        step(1, 1, -40, 2'b01, "R3");
        step(1, 0, -300, 2'b01, "R3");
        step(1, 1, -12, 2'b01, "R3");
        // R4 drift, then R5 overlapping windows, odd negative sum
        step(1, 0, 100, 2'b10, "R4");
        step(1, 1, 10, 2'b10, "R4");
        step(1, 0, 103, 2'b10, "R4");
        step(1, 1, 20, 2'b10, "R5");
        step(1, 0, -1, 2'b10, "R5");
        step(1, 1, 0, 2'b10, "R5");
        step(1, 0, -4, 2'b10, "R4");
        // R6 repeated tag-0 restarts the window from the newer sample
        step(1, 0, 8, 2'b10, "R6");
        step(1, 1, 2, 2'b10, "R6");
        step(1, 1, 3, 2'b10, "R6");
        // R7 tag-1 without a pending tag-0 is dropped
        step(0, 0, 0, 2'b00, "R7");
        step(1, 0, 60, 2'b00, "R6");
        step(1, 0, 61, 2'b00, "R6");
        step(1, 1, 1, 2'b00, "R6");
        step(1, 1, 5, 2'b00, "R7");
        step(1, 0, 9, 2'b00, "R7");
        step(1, 1, 4, 2'b00, "R7");
        // R8 full-scale extremes
        step(1, 0, VMAX, 2'b00, "R8");
        step(1, 1, VMIN, 2'b00, "R8");
        step(1, 0, VMIN, 2'b00, "R8");
        step(1, 1, VMAX, 2'b00, "R8");
        step(1, 0, VMAX, 2'b01, "R8");
        step(1, 1, VMAX, 2'b01, "R8");
        step(1, 0, VMIN, 2'b01, "R8");
        step(1, 1, VMIN, 2'b01, "R8");
        step(1, 0, VMIN, 2'b10, "R8");
        step(1, 1, VMAX, 2'b10, "R8");
        step(1, 0, VMIN, 2'b10, "R8");
        step(1, 1, VMIN, 2'b10, "R8");
        step(1, 0, VMAX, 2'b10, "R8");
        // R10 reserved mode acts as difference
        step(1, 1, 0, 2'b00, "R10");
        step(1, 0, 50, 2'b11, "R10");
        step(1, 1, 8, 2'b11, "R10");
        // method change mid-window: drift opens, difference closes
        step(1, 0, 40, 2'b10, "R2");
        step(1, 1, 6, 2'b10, "R2");
        step(1, 0, 15, 2'b00, "R2");
        step(1, 1, 5, 2'b00, "R2");
        step(0, 0, 0, 2'b00, "R9");
        step(0, 0, 0, 2'b00, "R9");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule